// File: doc/BRIEF.md
# Reference Oscillator Mode Decoder and Power-of-Two Divider

This block turns one 3-bit reference mode code into the enables that steer a frequency synthesizer's reference path, and produces a divided copy of the reference clock for use off the block. One code picks both the state of the on-chip crystal amplifier and what appears on the reference output. The crystal amplifier can be off, running on a crystal, or bypassed by an external reference. The output can be held low, passed through at full rate, or divided by 2, 4, 8 or 16.

The code is written into a mode register by a one-cycle write strobe. Until the first write, the register holds the divide-by-8 code. A standby flag stops the reference-counter clock enable without touching the oscillator or the divided output. Every write restarts the divider from zero, so a new ratio always begins with a clean low half-period.

Top module: `refosc`

## Requirements
- R1: Code 0 (shut down) drives osc_run, rcnt_en and path_en low and holds ref_out low, whatever the level of standby.
- R2: Code 1 (crystal) drives osc_run and path_en high, holds ref_out low, and drives rcnt_en high while standby is low.
- R3: While standby is high, rcnt_en is low in every mode, and osc_run keeps the value its mode gives it (high for code 1).
- R4: Code 2 (external reference, output off) drives path_en high and osc_run low, drives rcnt_en to the inverse of standby, and holds ref_out low.
- R5: Code 3 passes the reference clock straight to ref_out: ref_out is high while clk is high and low while clk is low.
- R6: Codes 4, 5, 6 and 7 divide clk by 2, 4, 8 and 16. In the m-th cycle after the write, ref_out equals bit (code-4) of m, with a 50% duty cycle. Standby does not change ref_out.
- R7: A write samples mode on the rising clk edge where cfg_wr is high and restarts the divider from zero, so ref_out is low in the cycle after a write of a divide code.
- R8: After reset the mode register holds code 6: ref_out is low during reset, path_en is high, osc_run is low, and ref_out then toggles every 4 cycles.
- R9: With cfg_wr low, changes on mode have no effect, and the divider keeps its sequence without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also the source for the divided output |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr | input | 1 | One-cycle strobe that loads mode into the mode register |
| mode | input | 3 | Reference mode code, 0 to 7 |
| standby | input | 1 | High stops the reference-counter clock enable |
| osc_run | output | 1 | Crystal amplifier enable |
| rcnt_en | output | 1 | Clock enable for the downstream reference counter |
| path_en | output | 1 | Internal reference path enable |
| ref_out | output | 1 | Divided, passed-through or held-low reference output |

## Verification
Two things can happen in the same cycle: a write and a divider step. A write of a divide code while a divide ratio is already running, in the middle of its high half-period, must win over the increment. The bench provokes this by rewriting code 7 twelve cycles into a divide-by-16 run, and by switching codes back to back. The scoreboard expects ref_out to return low and count from zero in the cycle after each write. A second collision is standby rising in the same write as a divide code: rcnt_en must fall while the divided output keeps its sequence.

// File: rtl/refosc_pkg.sv
package refosc_pkg;

  localparam int MODE_W       = 3;
  localparam int DIV_MAX_LOG2 = 4;
  localparam int CNT_W        = DIV_MAX_LOG2;
  localparam int TAP_W        = $clog2(DIV_MAX_LOG2);

  typedef enum logic [MODE_W-1:0] {
    M_SHUT  = 3'd0,
    M_XTAL  = 3'd1,
    M_REFIN = 3'd2,
    M_PASS  = 3'd3,
    M_DIV2  = 3'd4,
    M_DIV4  = 3'd5,
    M_DIV8  = 3'd6,
    M_DIV16 = 3'd7
  } mode_e;

  typedef struct packed {
    logic             osc_en;
    logic             path_en;
    logic             cnt_ok;
    logic             div_en;
    logic             pass;
    logic [TAP_W-1:0] tap;
  } ctrl_t;

endpackage

// File: rtl/refosc_rst_sync.sv
module refosc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_n_sync = sh_q[STAGES-1];

endmodule

// File: rtl/refosc_modereg.sv
module refosc_modereg #(
  parameter int                W       = 3,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (wr) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end

endmodule

// File: rtl/refosc_decode.sv
module refosc_decode
  import refosc_pkg::*;
(
  input  logic [MODE_W-1:0] code,
  output ctrl_t             ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (mode_e'(code))
      M_SHUT:  ctrl = '0;
      M_XTAL:  begin
        ctrl.osc_en  = 1'b1;
        ctrl.path_en = 1'b1;
        ctrl.cnt_ok  = 1'b1;
      end
      M_REFIN: begin
        ctrl.path_en = 1'b1;
        ctrl.cnt_ok  = 1'b1;
      end
      M_PASS:  begin
        ctrl.path_en = 1'b1;
        ctrl.cnt_ok  = 1'b1;
        ctrl.pass    = 1'b1;
      end
      default: begin
        ctrl.path_en = 1'b1;
        ctrl.cnt_ok  = 1'b1;
        ctrl.div_en  = 1'b1;
        ctrl.tap     = code[TAP_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/refosc_div.sv
module refosc_div #(
  parameter int CNT_W = 4,
  parameter int TAP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [TAP_W-1:0] tap,
  output logic             div_out
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
    else         cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign div_out = en & cnt_q[tap];

endmodule

// File: rtl/refosc.sv
module refosc
  import refosc_pkg::*;
#(
  parameter logic [2:0] RST_MODE    = 3'd6,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [2:0] mode,
  input  logic       standby,
  output logic       osc_run,
  output logic       rcnt_en,
  output logic       path_en,
  output logic       ref_out
);

  logic              rst_n_int;
  logic [MODE_W-1:0] mode_q;
  ctrl_t             ctrl;
  logic              div_bit;

  refosc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  refosc_modereg #(.W(MODE_W), .RST_VAL(RST_MODE)) u_mreg (
    .clk   (clk),
    .rst_n (rst_n_int),
    .wr    (cfg_wr),
    .d     (mode),
    .q     (mode_q)
  );

  refosc_decode u_dec (
    .code (mode_q),
    .ctrl (ctrl)
  );

  refosc_div #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (ctrl.div_en),
    .clr     (cfg_wr),
    .tap     (ctrl.tap),
    .div_out (div_bit)
  );

  assign osc_run = ctrl.osc_en;
  assign path_en = ctrl.path_en;
  assign rcnt_en = ctrl.cnt_ok & ~standby;
  assign ref_out = ctrl.pass ? clk : div_bit;

endmodule

// File: rtl/refosc_chk.sv
module refosc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [2:0] mode,
  input logic       standby,
  input logic [2:0] mode_q,
  input logic       osc_run,
  input logic       rcnt_en,
  input logic       path_en,
  input logic       ref_out
);

  a_r1_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0) |-> (!osc_run && !rcnt_en && !path_en && !ref_out));

  a_r2_crystal_run: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && !standby) |-> (osc_run && rcnt_en && !ref_out));

  a_r3_standby_stops_count: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !rcnt_en);

  a_r4_refin_no_output: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2) |-> (path_en && !osc_run && !ref_out));

  a_r6_half_rate_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4 && $past(mode_q) == 3'd4 && !$past(cfg_wr)) |-> (ref_out != $past(ref_out)));

  a_r7_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode[2]) |=> !ref_out);

  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(mode_q));

endmodule

bind refosc refosc_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_wr  (cfg_wr),
  .mode    (mode),
  .standby (standby),
  .mode_q  (mode_q),
  .osc_run (osc_run),
  .rcnt_en (rcnt_en),
  .path_en (path_en),
  .ref_out (ref_out)
);

// File: tb/refosc_tb.sv
`timescale 1ns/1ps
module refosc_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       standby = 1'b0;
  logic       osc_run, rcnt_en, path_en, ref_out;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic  out;
    logic  osc;
    logic  rcnt;
    logic  path;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  refosc u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .mode    (mode),
    .standby (standby),
    .osc_run (osc_run),
    .rcnt_en (rcnt_en),
    .path_en (path_en),
    .ref_out (ref_out)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: {out,osc,rcnt,path} actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t model(input logic [2:0] code, input logic stby, input int m, input string req);
    exp_t e;
    e.req  = req;
    e.osc  = (code == 3'd1);
    e.path = (code != 3'd0);
    e.rcnt = (code != 3'd0) && !stby;
    if (code == 3'd3)      e.out = 1'b1;
    else if (code >= 3'd4) e.out = ((m >> (code - 3'd4)) & 1) != 0;
    else                   e.out = 1'b0;
    return e;
  endfunction

  // Monitor: one expected item per rising edge, compared 1 ns after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, {ref_out, osc_run, rcnt_en, path_en}, {e.out, e.osc, e.rcnt, e.path});
      end
    end
  end

  // Driver: optional write, then push expectations for n cycles starting at count m0.
  task automatic run(input logic [2:0] code, input logic stby, input logic wr,
                     input logic [2:0] mode_in, input int m0, input int n, input string req);
    @(negedge clk);
    cfg_wr  = wr;
    mode    = mode_in;
    standby = stby;
    for (int i = 0; i < n; i++) sb_q.push_back(model(code, stby, m0 + i, req));
    @(negedge clk);
    cfg_wr = 1'b0;
    repeat (n - 2) @(negedge clk);
  endtask

  initial begin
    #400000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int changes;
    logic prev;
    // R8: state held during reset
    repeat (3) @(negedge clk);
    #1;
    check("R8 in reset", {ref_out, osc_run, rcnt_en, path_en}, 4'b0011);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R8: default divide-by-8, counted by changes over 16 samples
    changes = 0;
    @(posedge clk); #1; prev = ref_out;
    for (int i = 0; i < 15; i++) begin
      @(posedge clk); #1;
      if (ref_out != prev) changes++;
      prev = ref_out;
    end
    check("R8 default ratio", {3'b000, (changes == 3 || changes == 4)}, 4'b0001);
    check("R8 default enables", {1'b0, osc_run, rcnt_en, path_en}, 4'b0011);

    run(3'd0, 1'b0, 1'b1, 3'd0, 0, 4, "R1 shutdown");
    run(3'd0, 1'b1, 1'b1, 3'd0, 0, 4, "R1 shutdown standby");
    run(3'd1, 1'b0, 1'b1, 3'd1, 0, 4, "R2 crystal");
    run(3'd1, 1'b1, 1'b1, 3'd1, 0, 4, "R3 crystal standby");
    run(3'd2, 1'b0, 1'b1, 3'd2, 0, 4, "R4 refin off");
    run(3'd2, 1'b1, 1'b1, 3'd2, 0, 4, "R3 refin standby");
    run(3'd4, 1'b0, 1'b1, 3'd4, 0, 12, "R6 div2");
    run(3'd5, 1'b0, 1'b1, 3'd5, 0, 16, "R6 div4");
    run(3'd6, 1'b0, 1'b1, 3'd6, 0, 24, "R6 div8");
    run(3'd7, 1'b0, 1'b1, 3'd7, 0, 40, "R6 div16");
    run(3'd5, 1'b1, 1'b1, 3'd5, 0, 16, "R6 div4 standby");
    // R7: rewrite in the middle of a high half-period restarts from zero
    run(3'd7, 1'b0, 1'b1, 3'd7, 0, 12, "R7 first write");
    run(3'd7, 1'b0, 1'b1, 3'd7, 0, 20, "R7 rewrite restart");
    run(3'd6, 1'b0, 1'b1, 3'd6, 0, 6,  "R7 switch ratio");
    // R9: mode changes without a write are ignored, divider continues
    run(3'd6, 1'b0, 1'b0, 3'd0, 6, 10, "R9 ignore mode");
    run(3'd6, 1'b0, 1'b0, 3'd3, 16, 8, "R9 ignore mode 2");
    // R5: pass-through, high phase via scoreboard, low phase checked here
    run(3'd3, 1'b0, 1'b1, 3'd3, 0, 6, "R5 pass high");
    @(negedge clk); #1;
    check("R5 pass low phase", {ref_out, osc_run, rcnt_en, path_en}, 4'b0011);
    @(posedge clk); #1;
    check("R5 pass high phase", {ref_out, osc_run, rcnt_en, path_en}, 4'b1011);
    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule